// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one timer channel. A counter is loaded from a programmable reload value, counts down one step per tick, and reloads when it has passed through zero. Two match thresholds are compared against the running count. An event fires when the count reaches a threshold. An event can also fire when the count reaches zero. Each event inverts the level of the interrupt output and sets a sticky status bit, which the host clears with a one-cycle strobe.

The tick comes from one of two sources, chosen by a select input. The first is a one-cycle strobe from a 1 MHz reference. The second is the bus clock, which gives a tick on every cycle. The host reaches the channel through a simple write port and a read port, each with a two-bit register select. It reads one of: the count view, the reload value, match A or match B. A reload write is raised to a minimum that equals 20 microseconds of ticks at the rate selected when the write happens. The threshold values need no particular order: the larger one is reached first while counting down.

Top module: `dual_match_timer`

## Requirements
- R1: While enabled and with a nonzero reload value, each tick lowers the count by one. The tick after the count reaches zero reloads it, so one pass lasts reload+1 ticks.
- R2: A match register holding a value greater than or equal to the reload value acts as a zero threshold.
- R3: The match registers need no ordering. An event fires on the tick that brings the count to either nonzero effective threshold, so the larger threshold fires first within a pass.
- R4: Each event inverts `irq_level` and sets `evt_sts` on the same clock edge that updates the count. A `sts_clr` strobe clears `evt_sts`, and an event in the same cycle takes priority over the clear.
- R5: The tick that brings the count to zero fires an event only when `ovf_ie` is high or when either effective threshold is zero.
- R6: Register select encoding, the same for `rd_sel` and `wr_sel`: 0 = count view, 1 = reload, 2 = match A, 3 = match B. `rd_data` shows the selected register one cycle after `rd_sel` is sampled. The count view gives the live count while `run` is high and the reload value while `run` is low.
- R7: A write to select 0 while `run` is high places the written value in the running count at that edge. Counting continues from that value.
- R8: A reload write stores max(data, 20*rate), where rate is 1 when `use_ext` is high and BUS_MHZ otherwise.
- R9: When `use_ext` is high, only `ref_strobe` pulses advance the count. When `use_ext` is low, every clock cycle is a tick.
- R10: A reload write while `run` is high and the stored reload is zero arms the channel. The next tick loads the new reload value.
- R11: A rising edge of `run` arms the channel, and the next tick loads the reload value with no event. While `run` is low, the count, the interrupt level and the reload and match registers are held.
- R12: Synchronous reset clears the count, the reload value, both match registers, `irq_level` and `evt_sts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bus-clock tick source |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | One-cycle strobe from the 1 MHz reference |
| use_ext | input | 1 | Tick source select: 1 = reference strobe, 0 = bus clock |
| run | input | 1 | Channel enable |
| ovf_ie | input | 1 | Event at zero enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | W | Registered read data |
| sts_clr | input | 1 | Clears the sticky status bit |
| irq_level | output | 1 | Interrupt level, inverted on each event |
| evt_sts | output | 1 | Sticky event status bit |

## Verification
The count is run on the bus clock with the thresholds written in both orders, with `ovf_ie` on and off, and with one threshold at or above the reload value. The exact cycle of each interrupt toggle shows whether the sorting, the treatment of an out-of-range threshold as zero, and the zero-event condition are right. A run on the reference strobe with gaps between pulses shows that only the selected source advances the count. Count writes, a reload written into a channel that was never programmed, and a disable/re-enable sequence check that loading and freezing happen on the expected tick.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_MATCH_A = 2'd2,
    SEL_MATCH_B = 2'd3
  } dmt_sel_e;

  localparam int MIN_PERIOD_US = 20;
endpackage

// File: rtl/dmt_tick_src.sv
module dmt_tick_src (
  input  logic ref_strobe,
  input  logic use_ext,
  output logic tick
);
  // Bus clock ticks every cycle; the reference delivers one-cycle strobes.
  always_comb tick = use_ext ? ref_strobe : 1'b1;
endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int W       = 32,
  parameter int BUS_MHZ = 24,
  parameter int EXT_MHZ = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         use_ext,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] match_a_q,
  output logic [W-1:0] match_b_q,
  output logic         arm_req
);
  localparam logic [W-1:0] MIN_EXT = W'(MIN_PERIOD_US * EXT_MHZ);
  localparam logic [W-1:0] MIN_BUS = W'(MIN_PERIOD_US * BUS_MHZ);

  logic [W-1:0] min_now;
  logic [W-1:0] clamped;
  logic         wr_reload;

  always_comb begin
    min_now   = use_ext ? MIN_EXT : MIN_BUS;
    clamped   = (wr_data < min_now) ? min_now : wr_data;
    wr_reload = wr_en && (dmt_sel_e'(wr_sel) == SEL_RELOAD);
    // First programming of the reload value starts an enabled channel.
    arm_req   = wr_reload && (reload_q == '0) && (clamped != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q  <= '0;
      match_a_q <= '0;
      match_b_q <= '0;
    end else if (wr_en) begin
      case (dmt_sel_e'(wr_sel))
        SEL_RELOAD:  reload_q  <= clamped;
        SEL_MATCH_A: match_a_q <= wr_data;
        SEL_MATCH_B: match_b_q <= wr_data;
        default:     ;
      endcase
    end
  end

  // R8: a stored reload value never falls below the minimum in force at the write
  a_r8_reload_clamped: assert property (@(posedge clk) disable iff (rst)
    wr_reload |=> (reload_q >= $past(min_now)) && (reload_q != '0));
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         ovf_ie,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] match_a,
  input  logic [W-1:0] match_b,
  input  logic         arm_ext,
  input  logic         st_wr,
  input  logic [W-1:0] st_data,
  output logic [W-1:0] cnt_q,
  output logic         evt
);
  logic         run_q;
  logic         pend_q;
  logic         arm_now;
  logic         step;
  logic [W-1:0] eff_a, eff_b, m_hi, m_lo, nxt;
  logic         hit_hi, hit_lo, hit_zero;

  always_comb begin
    // Thresholds at or above the reload value collapse to zero.
    eff_a    = (match_a < reload) ? match_a : '0;
    eff_b    = (match_b < reload) ? match_b : '0;
    m_hi     = (eff_a > eff_b) ? eff_a : eff_b;
    m_lo     = (eff_a > eff_b) ? eff_b : eff_a;
    arm_now  = run && (!run_q || arm_ext);
    step     = run && !st_wr && !arm_now && tick && (reload != '0)
               && !pend_q && (cnt_q != '0);
    nxt      = cnt_q - 1'b1;
    hit_hi   = (m_hi != '0) && (nxt == m_hi);
    hit_lo   = (m_lo != '0) && (nxt == m_lo);
    hit_zero = (nxt == '0) && (ovf_ie || (m_lo == '0));
    evt      = step && (hit_hi || hit_lo || hit_zero);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      run_q <= run;
      if (run) begin
        if (st_wr) begin
          cnt_q  <= st_data;
          pend_q <= 1'b0;
        end else if (arm_now) begin
          pend_q <= 1'b1;
        end else if (tick && (reload != '0)) begin
          if (pend_q || (cnt_q == '0)) begin
            cnt_q  <= reload;
            pend_q <= 1'b0;
          end else begin
            cnt_q <= nxt;
          end
        end
      end
    end
  end

  // R1: an ordinary tick lowers the count by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (run && run_q && !arm_ext && !st_wr && tick && !pend_q
     && (reload != '0) && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R1: the tick after zero brings back the reload value
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && run_q && !arm_ext && !st_wr && tick && !pend_q
     && (reload != '0) && (cnt_q == '0)) |=> (cnt_q == $past(reload)));

  // R11: a disabled channel holds its count
  a_r11_freeze: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));

  // R7: a count write while enabled lands in the counter
  a_r7_count_load: assert property (@(posedge clk) disable iff (rst)
    (run && st_wr) |=> (cnt_q == $past(st_data)));
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic sts_clr,
  output logic irq_level,
  output logic evt_sts
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= 1'b0;
      evt_sts   <= 1'b0;
    end else begin
      irq_level <= irq_level ^ evt;
      evt_sts   <= evt | (evt_sts & ~sts_clr);
    end
  end

  // R4: each event inverts the level; no event, no change
  a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
    evt |=> (irq_level != $past(irq_level)));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !evt |=> (irq_level == $past(irq_level)));
  // R4: status is set by an event even when a clear arrives with it
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    evt |=> evt_sts);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int W       = 32,
  parameter int BUS_MHZ = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ref_strobe,
  input  logic         use_ext,
  input  logic         run,
  input  logic         ovf_ie,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         sts_clr,
  output logic         irq_level,
  output logic         evt_sts
);
  logic         tick;
  logic [W-1:0] reload_q, match_a_q, match_b_q, cnt_q;
  logic         arm_req, evt, st_wr;

  always_comb st_wr = wr_en && (dmt_sel_e'(wr_sel) == SEL_COUNT);

  dmt_tick_src u_tick (
    .ref_strobe (ref_strobe),
    .use_ext    (use_ext),
    .tick       (tick)
  );

  dmt_regs #(.W(W), .BUS_MHZ(BUS_MHZ), .EXT_MHZ(1)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .use_ext   (use_ext),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .reload_q  (reload_q),
    .match_a_q (match_a_q),
    .match_b_q (match_b_q),
    .arm_req   (arm_req)
  );

  dmt_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .tick    (tick),
    .ovf_ie  (ovf_ie),
    .reload  (reload_q),
    .match_a (match_a_q),
    .match_b (match_b_q),
    .arm_ext (arm_req),
    .st_wr   (st_wr),
    .st_data (wr_data),
    .cnt_q   (cnt_q),
    .evt     (evt)
  );

  dmt_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .sts_clr   (sts_clr),
    .irq_level (irq_level),
    .evt_sts   (evt_sts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (dmt_sel_e'(rd_sel))
        SEL_COUNT:   rd_data <= run ? cnt_q : reload_q;
        SEL_RELOAD:  rd_data <= reload_q;
        SEL_MATCH_A: rd_data <= match_a_q;
        default:     rd_data <= match_b_q;
      endcase
    end
  end

  // R6: with the channel stopped the count view mirrors the reload value
  a_r6_idle_view: assert property (@(posedge clk) disable iff (rst)
    (!run && (dmt_sel_e'(rd_sel) == SEL_COUNT)) |=> (rd_data == $past(reload_q)));
endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 0, rst = 1, ref_strobe = 0, use_ext = 0, run = 0, ovf_ie = 0;
  logic wr_en = 0, sts_clr = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [W-1:0] wr_data = 0, rd_data;
  logic irq_level, evt_sts;

  int checks = 0, errors = 0;
  int cyc = 0, nev = 0;
  int ev [0:63];
  logic irq_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_match_timer #(.W(W), .BUS_MHZ(2)) u_dut (
    .clk(clk), .rst(rst), .ref_strobe(ref_strobe), .use_ext(use_ext), .run(run),
    .ovf_ie(ovf_ie), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sts_clr(sts_clr),
    .irq_level(irq_level), .evt_sts(evt_sts));

  // Edge counter and log of the edges at which the interrupt level moved.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (irq_level !== irq_prev) begin
      if (nev < 64) ev[nev] = cyc;
      nev = nev + 1;
    end
    irq_prev = irq_level;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] d);
    @(negedge clk); rd_sel = s;
    @(posedge clk); #1; d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; run = 0; use_ext = 0; ovf_ie = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic start_run(output int t0);
    @(negedge clk); nev = 0; run = 1; t0 = cyc;
  endtask

  task automatic stop_run();
    @(negedge clk); run = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R12: reset state
  task automatic t_reset();
    logic [W-1:0] d;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d); chk("R12 reg after reset", d, 0);
    end
    chk("R12 irq after reset", irq_level, 0);
    chk("R12 sts after reset", evt_sts, 0);
  endtask

  // R8: clamping at both rates
  task automatic t_clamp();
    logic [W-1:0] d;
    use_ext = 1; wr(1, 5); rd(1, d); chk("R8 ext clamp", d, 20);
    use_ext = 0; wr(1, 5); rd(1, d); chk("R8 bus clamp", d, 40);
    wr(1, 100); rd(1, d); chk("R8 above minimum", d, 100);
  endtask

  // R1 R3 R5: thresholds written low-then-high, zero event enabled
  task automatic t_ordered();
    int t0;
    do_reset();
    wr(1, 50); wr(2, 10); wr(3, 30); ovf_ie = 1;
    start_run(t0); idle(80);
    chk("R3 events seen", nev >= 4, 1);
    chk("R3 larger threshold first", ev[0], t0 + 22);
    chk("R3 smaller threshold second", ev[1], t0 + 42);
    chk("R5 zero event with ovf_ie", ev[2], t0 + 52);
    chk("R1 wrap period", ev[3], t0 + 73);
    stop_run();
  endtask

  // R5: zero gives no event when disabled and both thresholds nonzero
  task automatic t_no_zero();
    int t0;
    do_reset();
    wr(1, 50); wr(2, 30); wr(3, 10); ovf_ie = 0;
    start_run(t0); idle(80);
    chk("R5 event count no zero", nev, 3);
    chk("R3 first", ev[0], t0 + 22);
    chk("R3 second", ev[1], t0 + 42);
    chk("R5 next pass skips zero", ev[2], t0 + 73);
    stop_run();
  endtask

  // R2: out-of-range threshold acts as zero
  task automatic t_out_of_range();
    int t0;
    do_reset();
    wr(1, 50); wr(2, 60); wr(3, 25); ovf_ie = 0;
    start_run(t0); idle(85);
    chk("R2 remaining threshold", ev[0], t0 + 27);
    chk("R2 zero event via collapsed match", ev[1], t0 + 52);
    chk("R2 next pass", ev[2], t0 + 78);
    stop_run();
  endtask

  // R9: reference strobe ticks only
  task automatic t_ext_tick();
    int t0;
    logic [W-1:0] d;
    do_reset();
    use_ext = 1; wr(1, 20); wr(2, 5); wr(3, 5); ovf_ie = 0;
    start_run(t0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ref_strobe = 1;
      @(negedge clk); ref_strobe = 0;
      idle(2);
    end
    rd(0, d); chk("R9 count after strobes", d, 15);
    idle(10);
    rd(0, d); chk("R9 no bus ticks with ext", d, 15);
    stop_run();
    use_ext = 0;
  endtask

  // R11 R6: freeze while disabled, reload on re-enable
  task automatic t_freeze();
    int t0;
    logic [W-1:0] d;
    do_reset();
    wr(1, 50); wr(2, 30); wr(3, 10); ovf_ie = 1;
    start_run(t0); idle(30);
    chk("R11 one event before stop", nev, 1);
    @(negedge clk); run = 0;
    idle(100);
    chk("R11 no events while stopped", nev, 1);
    rd(0, d); chk("R6 count view shows reload when stopped", d, 50);
    rd(2, d); chk("R11 match A kept", d, 30);
    rd(3, d); chk("R11 match B kept", d, 10);
    start_run(t0); idle(30);
    chk("R11 re-enable reloads", ev[0], t0 + 22);
    stop_run();
  endtask

  // R7: count write while enabled
  task automatic t_count_write();
    int t0;
    do_reset();
    wr(1, 200); ovf_ie = 1;
    start_run(t0); idle(5);
    @(negedge clk); nev = 0; t0 = cyc; wr_en = 1; wr_sel = 0; wr_data = 5;
    @(negedge clk); wr_en = 0;
    idle(10);
    chk("R7 zero after written count", ev[0], t0 + 6);
    stop_run();
  endtask

  // R10 R4: first reload write starts an enabled channel; sticky clear
  task automatic t_late_reload();
    int t0;
    logic [W-1:0] d;
    do_reset();
    ovf_ie = 1;
    start_run(t0); idle(20);
    chk("R10 idle without reload", nev, 0);
    rd(0, d); chk("R10 count idle at zero", d, 0);
    @(negedge clk); nev = 0; t0 = cyc; wr_en = 1; wr_sel = 1; wr_data = 40;
    @(negedge clk); wr_en = 0;
    idle(45);
    chk("R10 first zero event", ev[0], t0 + 42);
    chk("R4 level after one event", irq_level, 1);
    chk("R4 status set", evt_sts, 1);
    @(negedge clk); run = 0; sts_clr = 1;
    @(negedge clk); sts_clr = 0;
    chk("R4 status cleared", evt_sts, 0);
    chk("R4 level kept by clear", irq_level, 1);
    // R12: reset from a live state
    run = 1; idle(5);
    do_reset();
    chk("R12 irq cleared", irq_level, 0);
    rd(1, d); chk("R12 reload cleared", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_clamp();
    t_ordered();
    t_no_zero();
    t_out_of_range();
    t_ext_tick();
    t_freeze();
    t_count_write();
    t_late_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule